// File: doc/BRIEF.md
# 16-Line Edge-Interrupt GPIO Controller

This block gives a processor sixteen general-purpose pins behind a small 16-bit register interface. Each pin can be an input or an output. Output pins drive a stored latch value onto the pin bus. Input pins pass through a two-flop sampling stage. From there they can be read back through a per-pin enable, and they can raise an interrupt on a programmable edge.

Each pin has one polarity bit that picks rising or falling edge detection. A detected edge on an unmasked input pin sets a sticky status bit and raises a single level interrupt line. Any full-width write to the status register drops the line. Status bits clear only where a 1 is written.

Register accesses are single-cycle requests. A small access state machine has two states. `ACC_IDLE` means no read response is pending. `ACC_RESP` means read data is valid on the response port. A read request moves the machine to `ACC_RESP` from either state, so back-to-back reads keep it there. A cycle with no read request returns it to `ACC_IDLE`. Writes take effect at the clock edge that accepts them and do not change state.

Top module: `gpio16_ctrl`

## Requirements
- R1: After reset the direction register reads 0xFFFF (all inputs), the interrupt mask reads 0xFFFF, the pin-enable register reads 0xFFFF, and the output latch, edge select and status registers read 0. The interrupt line is low and no pin is driven.
- R2: A read request is answered one cycle later with `rsp_valid` high and the register value on `rsp_data`. The register offsets are:
  - input data 0x00
  - output latch 0x04
  - direction 0x08
  - edge select 0x0C
  - interrupt mask 0x10
  - interrupt status 0x14
  - pin enable 0x18

  Any other offset reads 0 and ignores writes.
- R3: A read of offset 0x00 returns the two-flop-sampled pin inputs ANDed bitwise with the pin-enable register.
- R4: An edge-select bit of 1 detects a rising edge on that pin, and 0 detects a falling edge. An edge applied before clock edge k is visible in status and on `irq` after clock edge k+2.
- R5: An edge counts only when the pin's direction bit is 1 (input) and its mask bit is 0. Any other edge leaves status and `irq` unchanged.
- R6: `pins_oe` equals the inverted direction register. `pins_out` carries the latch bit on pins whose direction bit is 0 and 0 elsewhere. A direction change to output drives the stored latch value from the next cycle on, and latch writes on input pins do not reach `pins_out`.
- R7: A counted edge sets its status bit and raises `irq` in the same cycle.
- R8: Any full-width write to offset 0x14 drops `irq` on the next cycle, whatever the data, unless a counted edge occurs in that same cycle. The write clears only the status bits where the data has a 1.
- R9: An access with `acc_wide` low is a narrow access. A narrow write changes nothing, and a narrow read returns 0.
- R10: Writes to the input data offset 0x00 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_req | input | 1 | Register access request, one cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | 1 = full 16-bit access, 0 = narrow access |
| acc_addr | input | AW | Byte offset of the register |
| acc_wdata | input | W | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | W | Read data |
| pins_in | input | W | Pin input bus |
| pins_out | output | W | Pin output values |
| pins_oe | output | W | Pin output enables |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with W = 16 and AW = 8. This lets every one of the sixteen pins take part in edge, mask and direction patterns, and puts unmapped offsets such as 0x1C inside the address space. A behavioural model fed by a history queue of pin inputs predicts the interrupt, pin and read outputs every cycle. Directed sequences cover both edge polarities, masked pins, edges on output pins, zero-data status writes and narrow accesses. A random phase follows, mixing these behaviours.

// File: rtl/gpio16_pkg.sv
package gpio16_pkg;

    // Register byte offsets
    localparam int unsigned OFF_PIN_IN   = 32'h00;
    localparam int unsigned OFF_OUT_LAT  = 32'h04;
    localparam int unsigned OFF_DIR      = 32'h08;
    localparam int unsigned OFF_EDGE_SEL = 32'h0C;
    localparam int unsigned OFF_MASK     = 32'h10;
    localparam int unsigned OFF_STATUS   = 32'h14;
    localparam int unsigned OFF_PIN_EN   = 32'h18;

    // Read response tracking
    typedef enum logic [0:0] {
        ACC_IDLE = 1'b0,
        ACC_RESP = 1'b1
    } acc_state_t;

endpackage

// File: rtl/gpio16_sync.sv
module gpio16_sync #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/gpio16_edge.sv
module gpio16_edge #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] samp,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] pol,
    output logic [W-1:0] hit
);
    logic [W-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= '0;
        else        last_q <= samp;
    end

    for (genvar p = 0; p < W; p++) begin : g_pin
        logic rose, fell, seen;
        assign rose   = samp[p] & ~last_q[p];
        assign fell   = ~samp[p] & last_q[p];
        assign seen   = pol[p] ? rose : fell;
        assign hit[p] = seen & dir[p] & ~mask[p];
    end
endmodule

// File: rtl/gpio16_drive.sv
module gpio16_drive #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] dir,
    input  logic [W-1:0] lat,
    output logic [W-1:0] pins_out,
    output logic [W-1:0] pins_oe
);
    for (genvar p = 0; p < W; p++) begin : g_pin
        assign pins_oe[p]  = ~dir[p];
        assign pins_out[p] = dir[p] ? 1'b0 : lat[p];
    end
endmodule

// File: rtl/gpio16_ctrl.sv
module gpio16_ctrl
    import gpio16_pkg::*;
#(
    parameter int unsigned W  = 16,
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_req,
    input  logic          acc_we,
    input  logic          acc_wide,
    input  logic [AW-1:0] acc_addr,
    input  logic [W-1:0]  acc_wdata,
    output logic          rsp_valid,
    output logic [W-1:0]  rsp_data,
    input  logic [W-1:0]  pins_in,
    output logic [W-1:0]  pins_out,
    output logic [W-1:0]  pins_oe,
    output logic          irq
);
    localparam logic [AW-1:0] A_PIN_IN = AW'(OFF_PIN_IN);
    localparam logic [AW-1:0] A_LAT    = AW'(OFF_OUT_LAT);
    localparam logic [AW-1:0] A_DIR    = AW'(OFF_DIR);
    localparam logic [AW-1:0] A_EDGE   = AW'(OFF_EDGE_SEL);
    localparam logic [AW-1:0] A_MASK   = AW'(OFF_MASK);
    localparam logic [AW-1:0] A_STAT   = AW'(OFF_STATUS);
    localparam logic [AW-1:0] A_PEN    = AW'(OFF_PIN_EN);

    logic [W-1:0] sampled, edge_hit;
    logic [W-1:0] dir_q, mask_q, stat_q, lat_q, pol_q, pen_q;
    logic [W-1:0] rd_word, rsp_q;
    logic         irq_q, wr_en, rd_en, stat_wr;
    acc_state_t   st_q, st_d;

    assign wr_en   = acc_req & acc_we & acc_wide;
    assign rd_en   = acc_req & ~acc_we;
    assign stat_wr = wr_en && (acc_addr == A_STAT);

    gpio16_sync #(.W(W)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pins_in), .q(sampled)
    );

    gpio16_edge #(.W(W)) u_edge (
        .clk(clk), .rst_n(rst_n), .samp(sampled), .dir(dir_q),
        .mask(mask_q), .pol(pol_q), .hit(edge_hit)
    );

    gpio16_drive #(.W(W)) u_drive (
        .dir(dir_q), .lat(lat_q), .pins_out(pins_out), .pins_oe(pins_oe)
    );

    // Access state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ACC_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ACC_IDLE: st_d = rd_en ? ACC_RESP : ACC_IDLE;
            ACC_RESP: st_d = rd_en ? ACC_RESP : ACC_IDLE;
            default:  st_d = ACC_IDLE;
        endcase
    end

    // Outputs of the access machine
    always_comb begin
        rsp_valid = (st_q == ACC_RESP);
        rsp_data  = rsp_q;
    end

    // Read selection
    always_comb begin
        rd_word = '0;
        if (acc_wide) begin
            case (acc_addr)
                A_PIN_IN: rd_word = sampled & pen_q;
                A_LAT:    rd_word = lat_q;
                A_DIR:    rd_word = dir_q;
                A_EDGE:   rd_word = pol_q;
                A_MASK:   rd_word = mask_q;
                A_STAT:   rd_word = stat_q;
                A_PEN:    rd_word = pen_q;
                default:  rd_word = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rsp_q <= '0;
        else if (rd_en) rsp_q <= rd_word;
    end

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '1;
            mask_q <= '1;
            pen_q  <= '1;
            lat_q  <= '0;
            pol_q  <= '0;
        end else if (wr_en) begin
            case (acc_addr)
                A_LAT:   lat_q  <= acc_wdata;
                A_DIR:   dir_q  <= acc_wdata;
                A_EDGE:  pol_q  <= acc_wdata;
                A_MASK:  mask_q <= acc_wdata;
                A_PEN:   pen_q  <= acc_wdata;
                default: ;
            endcase
        end
    end

    // Status and interrupt line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            stat_q <= (stat_q & ~(stat_wr ? acc_wdata : '0)) | edge_hit;
            if (|edge_hit)    irq_q <= 1'b1;
            else if (stat_wr) irq_q <= 1'b0;
        end
    end

    assign irq = irq_q;
endmodule

// File: rtl/gpio16_ctrl_chk.sv
module gpio16_ctrl_chk
    import gpio16_pkg::*;
#(
    parameter int unsigned W  = 16,
    parameter int unsigned AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          acc_req,
    input logic          acc_we,
    input logic          acc_wide,
    input logic [AW-1:0] acc_addr,
    input logic [W-1:0]  acc_wdata,
    input logic          rsp_valid,
    input logic [W-1:0]  rsp_data,
    input logic [W-1:0]  pins_oe,
    input logic          irq,
    input logic [W-1:0]  hit
);
    localparam logic [AW-1:0] C_DIR  = AW'(OFF_DIR);
    localparam logic [AW-1:0] C_STAT = AW'(OFF_STATUS);

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !acc_we) |=> rsp_valid); // R2

    AST_NARROW_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !acc_we && !acc_wide) |=> (rsp_data == '0)); // R9

    AST_DIR_DRIVES_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_we && acc_wide && acc_addr == C_DIR) |=> (pins_oe == ~$past(acc_wdata))); // R6

    AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|hit)); // R7

    AST_STATUS_WRITE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_we && acc_wide && acc_addr == C_STAT && !(|hit)) |=> !irq); // R8
endmodule

bind gpio16_ctrl gpio16_ctrl_chk #(.W(W), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_we(acc_we),
    .acc_wide(acc_wide), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .pins_oe(pins_oe),
    .irq(irq), .hit(edge_hit)
);

// File: tb/test_gpio16_ctrl.sv
`timescale 1ns/1ps
module test_gpio16_ctrl;
    localparam int W  = 16;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_req = 1'b0, acc_we = 1'b0, acc_wide = 1'b1;
    logic [AW-1:0] acc_addr = '0;
    logic [W-1:0]  acc_wdata = '0;
    logic          rsp_valid;
    logic [W-1:0]  rsp_data;
    logic [W-1:0]  pins_in = '0;
    logic [W-1:0]  pins_out, pins_oe;
    logic          irq;

    int vecs = 0, bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio16_ctrl #(.W(W), .AW(AW)) i_gpio16_ctrl (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_we(acc_we),
        .acc_wide(acc_wide), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .pins_in(pins_in),
        .pins_out(pins_out), .pins_oe(pins_oe), .irq(irq)
    );

    task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [W-1:0] m_dir, m_mask, m_stat, m_lat, m_pol, m_pen, m_rd;
    logic         m_irq, m_rv;
    logic [W-1:0] hist[$];

    function automatic logic [W-1:0] m_read(logic [AW-1:0] a, logic wide);
        if (!wide) return '0;
        case (a)
            8'h00: return hist[1] & m_pen;
            8'h04: return m_lat;
            8'h08: return m_dir;
            8'h0C: return m_pol;
            8'h10: return m_mask;
            8'h14: return m_stat;
            8'h18: return m_pen;
            default: return '0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir = '1; m_mask = '1; m_pen = '1;
            m_stat = '0; m_lat = '0; m_pol = '0;
            m_irq = 1'b0; m_rv = 1'b0; m_rd = '0;
            hist = '{'0, '0, '0};
        end else begin
            logic [W-1:0] nw, od, ev, q;
            logic wr;
            nw = hist[1]; od = hist[2];
            ev = (m_pol & nw & ~od) | (~m_pol & ~nw & od);
            q  = ev & m_dir & ~m_mask;
            wr = acc_req && acc_we && acc_wide;
            if (acc_req && !acc_we) begin
                m_rv = 1'b1;
                m_rd = m_read(acc_addr, acc_wide);
            end else m_rv = 1'b0;
            if (wr) begin
                case (acc_addr)
                    8'h04: m_lat  = acc_wdata;
                    8'h08: m_dir  = acc_wdata;
                    8'h0C: m_pol  = acc_wdata;
                    8'h10: m_mask = acc_wdata;
                    8'h18: m_pen  = acc_wdata;
                    8'h14: m_stat = m_stat & ~acc_wdata;
                    default: ;
                endcase
            end
            m_stat = m_stat | q;
            if (|q) m_irq = 1'b1;
            else if (wr && acc_addr == 8'h14) m_irq = 1'b0;
            hist.push_front(pins_in);
            void'(hist.pop_back());
        end
        #2;
        if (rst_n && !done) begin
            chk("R2", "rsp_valid", W'(rsp_valid), W'(m_rv));
            if (m_rv) chk("R2", "rsp_data", rsp_data, m_rd);
            chk("R6", "pins_oe", pins_oe, ~m_dir);
            chk("R6", "pins_out", pins_out, m_lat & ~m_dir);
            chk("R7", "irq", W'(irq), W'(m_irq));
        end
    end

    task automatic access(logic we, logic wide, logic [AW-1:0] a, logic [W-1:0] d);
        @(negedge clk);
        acc_req = 1'b1; acc_we = we; acc_wide = wide; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_req = 1'b0; acc_we = 1'b0; acc_wide = 1'b1;
    endtask

    task automatic wr(logic [AW-1:0] a, logic [W-1:0] d);
        access(1'b1, 1'b1, a, d);
    endtask

    task automatic rd(logic [AW-1:0] a, logic [W-1:0] exp, string tag);
        access(1'b0, 1'b1, a, '0);
        chk(tag, "read", rsp_data, exp);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        chk("R1", "irq", W'(irq), '0);
        chk("R1", "pins_oe", pins_oe, '0);
        rd(8'h08, 16'hFFFF, "R1");
        rd(8'h10, 16'hFFFF, "R1");
        rd(8'h18, 16'hFFFF, "R1");
        rd(8'h04, 16'h0000, "R1");
        rd(8'h0C, 16'h0000, "R1");
        rd(8'h14, 16'h0000, "R1");
        // R2 unmapped offset
        rd(8'h1C, 16'h0000, "R2");
        // R6 output drive follows direction
        wr(8'h04, 16'h00F0);
        chk("R6", "latch on inputs", pins_out, 16'h0000);
        wr(8'h08, 16'hFF0F);
        chk("R6", "drive after dir", pins_out, 16'h00F0);
        chk("R6", "oe after dir", pins_oe, 16'h00F0);
        wr(8'h04, 16'h0F0F);
        chk("R6", "latch gated", pins_out, 16'h0000);
        wr(8'h08, 16'hFFFF);
        // R3 input readback through pin enable
        pins_in = 16'h1234;
        idle(3);
        wr(8'h18, 16'h00FF);
        rd(8'h00, 16'h0034, "R3");
        // R10 write to input offset ignored
        wr(8'h00, 16'h0000);
        rd(8'h00, 16'h0034, "R10");
        wr(8'h18, 16'hFFFF);
        rd(8'h00, 16'h1234, "R3");
        pins_in = 16'h0000;
        idle(4);
        // R4 rising edge on pin 0
        wr(8'h10, 16'hFFFE);
        wr(8'h0C, 16'h0001);
        pins_in = 16'h0001;
        idle(2);
        chk("R4", "irq before latency", W'(irq), '0);
        idle(2);
        chk("R4", "irq rising", W'(irq), 16'h0001);
        rd(8'h14, 16'h0001, "R7");
        // R8 zero-data status write drops irq, keeps status
        wr(8'h14, 16'h0000);
        chk("R8", "irq after write", W'(irq), '0);
        rd(8'h14, 16'h0001, "R8");
        wr(8'h14, 16'h0001);
        rd(8'h14, 16'h0000, "R8");
        // R4 falling edge
        wr(8'h0C, 16'h0000);
        pins_in = 16'h0000;
        idle(4);
        chk("R4", "irq falling", W'(irq), 16'h0001);
        wr(8'h14, 16'hFFFF);
        chk("R8", "irq cleared", W'(irq), '0);
        // R5 masked pin
        pins_in = 16'h0002;
        idle(4);
        pins_in = 16'h0000;
        idle(4);
        chk("R5", "masked irq", W'(irq), '0);
        rd(8'h14, 16'h0000, "R5");
        // R5 output pin ignores edges
        wr(8'h08, 16'hFFFE);
        wr(8'h0C, 16'h0001);
        pins_in = 16'h0001;
        idle(4);
        chk("R5", "output pin irq", W'(irq), '0);
        rd(8'h14, 16'h0000, "R5");
        // R9 narrow accesses
        access(1'b1, 1'b0, 8'h08, 16'h0000);
        chk("R9", "narrow write", pins_oe, 16'h0001);
        access(1'b0, 1'b0, 8'h08, '0);
        chk("R9", "narrow read", rsp_data, 16'h0000);
        access(1'b1, 1'b0, 8'h14, 16'hFFFF);
        // random phase
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] a;
            a = AW'(($urandom % 8) * 4);
            pins_in = W'($urandom);
            if ($urandom % 3 == 0) idle(1);
            else access(($urandom % 2) == 1, ($urandom % 8) != 0, a, W'($urandom));
        end
        idle(3);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end
endmodule